// File: doc/BRIEF.md
# Memory Controller Event Statistics Counter

This block watches the event strobes a memory controller arbiter raises each memory clock and tallies the ones software asks about. Two gather counters run side by side. Each has its own control word that picks one event class and can narrow the count to one requesting client and to events that did, or did not, meet a chosen priority-promotion condition. A shared elapsed-clock counter measures the sampling window, so software can turn the two counts into utilisation figures.

Software drives it through a small register bus. It loads the two control words and a clock limit, clears the counters, issues an enable command, waits, issues a disable command and then reads the two counts and the elapsed clocks. The elapsed-clock counter stops at the limit, and counting stops with it, which closes the window in hardware. Event counters saturate instead of wrapping.

Top module: `mc_evstat`

## Requirements
- R1: After hardware reset both counts, the elapsed clocks, both control words and the command field read zero, and the clock limit reads all ones (CLK_W bits).
- R2: A control word (offset 0xA8 for counter 0, 0xAC for counter 1) keeps only its fields: client ID in bits 13:8, event select in 23:16, priority kind in 25:24, client-filter enable in bit 26, priority-filter mode in 29:28. Every other bit reads zero, so writing all ones reads back 0x37FF3F00.
- R3: Event select code n (0 to 8) counts a cycle in which ev_valid is high and bit n of ev_class is high. Codes above 8 never count.
- R4: With the client-filter enable clear, events from any ev_client count. With it set, only events whose ev_client equals the programmed ID count.
- R5: Priority kind code k (0 to 2) selects bit k of ev_prio as the priority condition; kind 3 is a condition that is never true. Filter mode 0 or 3 ignores the condition, mode 1 counts only events without it, mode 2 only events with it.
- R6: Writing offset 0x90 executes the command in bits 9:8 (0 reset, 1 clear, 2 disable, 3 enable) and that field reads back the last command. After an enable, events are counted from the next clock edge on; after a disable, counts and clocks hold their values.
- R7: The clear command zeroes both counts and the elapsed clocks on the edge it is written, leaving the control words, the limit and the gathering state unchanged.
- R8: The reset command zeroes both counts and the elapsed clocks and stops gathering.
- R9: While gathering, the elapsed-clock counter (offset 0xA4) advances by one each clock while it is below the limit (offset 0xA0) and then stops. Events are counted only on clocks where the elapsed count is below the limit.
- R10: Each event counter (offsets 0xB8 and 0xBC) advances by at most one per clock and holds at all ones (CNT_W bits) instead of wrapping.
- R11: Reads of offsets other than the seven listed return zero; writes to the count and elapsed-clock offsets change nothing.
- R12: The two counters are independent: each counts by its own control word from the same event strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_valid | input | 1 | An arbitrated event is present this clock |
| ev_client | input | 6 | Client ID of the event |
| ev_class | input | 9 | One bit per event class, bit n for select code n |
| ev_prio | input | 3 | Priority-promotion conditions, bit k for kind code k |

## Verification
The bench runs a cycle-accurate model of the register and counting rules beside the design and compares every readback against it, under random control words that mix select codes above 8, kind 3 and filter mode 3 with random client IDs and event strobes. Directed cases go after the edges: a limit of 5 must give exactly 5 clocks and 5 events, so a design that compared with less-or-equal or kept counting past the window would read 6 or more; 300 back-to-back events on an 8-bit counter must read 255, where a wrapping counter reads 44. A clear while gathering must leave the enable in force and the control word intact, a reset command must stop the window, and a write to a count offset must leave its value as it was.

// File: rtl/mc_evstat_pkg.sv
package mc_evstat_pkg;

  localparam int ID_W   = 6;
  localparam int N_EV   = 9;
  localparam int N_PRI  = 3;

  localparam logic [7:0] OFS_GCTL  = 8'h90;
  localparam logic [7:0] OFS_LIMIT = 8'hA0;
  localparam logic [7:0] OFS_CLKS  = 8'hA4;
  localparam logic [7:0] OFS_CTL0  = 8'hA8;
  localparam logic [7:0] OFS_CTL1  = 8'hAC;
  localparam logic [7:0] OFS_CNT0  = 8'hB8;
  localparam logic [7:0] OFS_CNT1  = 8'hBC;

  typedef enum logic [1:0] {
    CMD_RESET   = 2'd0,
    CMD_CLEAR   = 2'd1,
    CMD_DISABLE = 2'd2,
    CMD_ENABLE  = 2'd3
  } gcmd_e;

  typedef enum logic [1:0] {
    PF_OFF    = 2'd0,
    PF_WITHOUT = 2'd1,
    PF_WITH   = 2'd2,
    PF_SPARE  = 2'd3
  } pfilt_e;

  typedef struct packed {
    logic [1:0]      filt;
    logic            cfe;
    logic [1:0]      kind;
    logic [7:0]      sel;
    logic [ID_W-1:0] id;
  } gctl_t;

  function automatic gctl_t word_to_ctl(input logic [31:0] w);
    gctl_t c;
    c.id   = w[13:8];
    c.sel  = w[23:16];
    c.kind = w[25:24];
    c.cfe  = w[26];
    c.filt = w[29:28];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(input gctl_t c);
    logic [31:0] w;
    w        = '0;
    w[13:8]  = c.id;
    w[23:16] = c.sel;
    w[25:24] = c.kind;
    w[26]    = c.cfe;
    w[29:28] = c.filt;
    return w;
  endfunction

endpackage

// File: rtl/evstat_clkcnt.sv
module evstat_clkcnt #(
  parameter int CLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gath,
  input  logic             clr,
  input  logic [CLK_W-1:0] limit,
  output logic [CLK_W-1:0] clks
);

  logic [CLK_W-1:0] clks_q, clks_d;
  logic             clks_en;

  always_comb begin
    clks_d  = clks_q;
    clks_en = 1'b0;
    if (clr) begin
      clks_d  = '0;
      clks_en = 1'b1;
    end else if (gath && (clks_q < limit)) begin
      clks_d  = clks_q + 1'b1;
      clks_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clks_q <= '0;
    else if (clks_en) clks_q <= clks_d;
  end

  assign clks = clks_q;

  AST_CLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!gath && !clr) |=> $stable(clks_q)); // R6

  AST_CLK_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (clks_q >= limit)) |=> $stable(clks_q)); // R9

endmodule

// File: rtl/evstat_gather.sv
module evstat_gather
  import mc_evstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gctl_t            ctl,
  input  logic             clr,
  input  logic             active,
  input  logic             ev_valid,
  input  logic [ID_W-1:0]  ev_client,
  input  logic [N_EV-1:0]  ev_class,
  input  logic [N_PRI-1:0] ev_prio,
  output logic [CNT_W-1:0] count
);

  logic             cls_hit, cli_ok, pri_cond, pri_ok, hit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cls_hit = 1'b0;
    for (int i = 0; i < N_EV; i++) begin
      if (ctl.sel == 8'(i)) cls_hit = ev_class[i];
    end
  end

  always_comb begin
    pri_cond = 1'b0;
    for (int k = 0; k < N_PRI; k++) begin
      if (ctl.kind == 2'(k)) pri_cond = ev_prio[k];
    end
  end

  always_comb begin
    case (pfilt_e'(ctl.filt))
      PF_WITHOUT: pri_ok = !pri_cond;
      PF_WITH:    pri_ok = pri_cond;
      default:    pri_ok = 1'b1;
    endcase
  end

  assign cli_ok = !ctl.cfe || (ev_client == ctl.id);
  assign hit    = ev_valid && cls_hit && cli_ok && pri_ok;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (active && hit && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt_q == {CNT_W{1'b1}})) |=> (cnt_q == {CNT_W{1'b1}})); // R10

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !active) |=> $stable(cnt_q)); // R9

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/mc_evstat.sv
module mc_evstat
  import mc_evstat_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_valid,
  input  logic [ID_W-1:0]  ev_client,
  input  logic [N_EV-1:0]  ev_class,
  input  logic [N_PRI-1:0] ev_prio
);

  localparam int N_GATH = 2;

  logic             cmd_wr;
  gcmd_e            cmd;
  logic             clr;
  logic             gath_q, gath_d, gath_en;
  logic [1:0]       cmd_q;
  logic [CLK_W-1:0] limit_q;
  logic             limit_en;
  gctl_t            ctl_q  [N_GATH];
  logic             ctl_en [N_GATH];
  logic [CNT_W-1:0] cnt    [N_GATH];
  logic [CLK_W-1:0] clks;
  logic             active;

  assign cmd_wr = reg_wr && (reg_addr == OFS_GCTL);
  assign cmd    = gcmd_e'(reg_wdata[9:8]);
  assign clr    = cmd_wr && ((cmd == CMD_RESET) || (cmd == CMD_CLEAR));

  always_comb begin
    gath_d  = gath_q;
    gath_en = cmd_wr;
    case (cmd)
      CMD_RESET:   gath_d = 1'b0;
      CMD_DISABLE: gath_d = 1'b0;
      CMD_ENABLE:  gath_d = 1'b1;
      default:     gath_d = gath_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gath_q <= 1'b0;
      cmd_q  <= 2'd0;
    end else if (gath_en) begin
      gath_q <= gath_d;
      cmd_q  <= reg_wdata[9:8];
    end
  end

  assign limit_en = reg_wr && (reg_addr == OFS_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= {CLK_W{1'b1}};
    else if (limit_en) limit_q <= reg_wdata[CLK_W-1:0];
  end

  evstat_clkcnt #(.CLK_W(CLK_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .gath  (gath_q),
    .clr   (clr),
    .limit (limit_q),
    .clks  (clks)
  );

  assign active = gath_q && (clks < limit_q);

  for (genvar g = 0; g < N_GATH; g++) begin : g_gath
    localparam logic [7:0] CTL_OFS = (g == 0) ? OFS_CTL0 : OFS_CTL1;

    assign ctl_en[g] = reg_wr && (reg_addr == CTL_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctl_q[g] <= '0;
      else if (ctl_en[g]) ctl_q[g] <= word_to_ctl(reg_wdata);
    end

    evstat_gather #(.CNT_W(CNT_W)) u_gath (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl_q[g]),
      .clr       (clr),
      .active    (active),
      .ev_valid  (ev_valid),
      .ev_client (ev_client),
      .ev_class  (ev_class),
      .ev_prio   (ev_prio),
      .count     (cnt[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_GCTL:  reg_rdata[9:8]         = cmd_q;
      OFS_LIMIT: reg_rdata[CLK_W-1:0]   = limit_q;
      OFS_CLKS:  reg_rdata[CLK_W-1:0]   = clks;
      OFS_CTL0:  reg_rdata              = ctl_to_word(ctl_q[0]);
      OFS_CTL1:  reg_rdata              = ctl_to_word(ctl_q[1]);
      OFS_CNT0:  reg_rdata[CNT_W-1:0]   = cnt[0];
      OFS_CNT1:  reg_rdata[CNT_W-1:0]   = cnt[1];
      default:   reg_rdata              = '0;
    endcase
  end

  AST_STOP_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd == CMD_RESET)) |=> (!gath_q && (clks == '0))); // R8

  AST_CLEAR_KEEPS_GATH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd == CMD_CLEAR)) |=> (gath_q == $past(gath_q))); // R7

  AST_ENABLE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd == CMD_ENABLE)) |=> gath_q); // R6

endmodule

// File: tb/tb_mc_evstat.sv
`timescale 1ns/1ps
module tb_mc_evstat;

  localparam int CNT_W = 8;
  localparam int CLK_W = 16;
  localparam logic [31:0] CTL_MASK = 32'h37FF3F00;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ev_valid;
  logic [5:0]  ev_client;
  logic [8:0]  ev_class;
  logic [2:0]  ev_prio;

  int checks, errors;
  bit done;

  mc_evstat #(.CNT_W(CNT_W), .CLK_W(CLK_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_client(ev_client), .ev_class(ev_class), .ev_prio(ev_prio)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model of the register and counting rules
  logic [31:0] m_ctl [2];
  logic [31:0] m_cnt [2];
  logic [31:0] m_clk, m_lim;
  logic [1:0]  m_cmd;
  bit          m_gath;

  function automatic bit m_hit(input logic [31:0] c);
    bit cls_ok, cli_ok, pc, pri_ok;
    logic [7:0] sel;
    logic [1:0] kind, filt;
    sel  = c[23:16];
    kind = c[25:24];
    filt = c[29:28];
    cls_ok = (sel < 9) ? ev_class[sel[3:0]] : 1'b0;
    cli_ok = !c[26] || (ev_client == c[13:8]);
    pc     = (kind < 3) ? ev_prio[kind] : 1'b0;
    case (filt)
      2'd1:    pri_ok = !pc;
      2'd2:    pri_ok = pc;
      default: pri_ok = 1'b1;
    endcase
    return ev_valid && cls_ok && cli_ok && pri_ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl[0] = 0; m_ctl[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_clk = 0; m_lim = (1 << CLK_W) - 1; m_cmd = 0; m_gath = 0;
    end else begin
      bit act;
      act = m_gath && (m_clk < m_lim);
      for (int g = 0; g < 2; g++)
        if (act && m_hit(m_ctl[g]) && m_cnt[g] != (1 << CNT_W) - 1) m_cnt[g]++;
      if (m_gath && m_clk < m_lim) m_clk++;
      if (reg_wr) begin
        case (reg_addr)
          8'h90: begin
            m_cmd = reg_wdata[9:8];
            case (reg_wdata[9:8])
              2'd0: begin m_cnt[0] = 0; m_cnt[1] = 0; m_clk = 0; m_gath = 0; end
              2'd1: begin m_cnt[0] = 0; m_cnt[1] = 0; m_clk = 0; end
              2'd2: m_gath = 0;
              default: m_gath = 1;
            endcase
          end
          8'hA0: m_lim = reg_wdata & ((1 << CLK_W) - 1);
          8'hA8: m_ctl[0] = reg_wdata & CTL_MASK;
          8'hAC: m_ctl[1] = reg_wdata & CTL_MASK;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h90: return {22'd0, m_cmd, 8'd0};
      8'hA0: return m_lim;
      8'hA4: return m_clk;
      8'hA8: return m_ctl[0];
      8'hAC: return m_ctl[1];
      8'hB8: return m_cnt[0];
      8'hBC: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic quiet();
    ev_valid = 0; ev_client = 0; ev_class = 0; ev_prio = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    quiet();
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chkm(input logic [7:0] a, input string tag);
    @(negedge clk);
    quiet();
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== m_read(a)) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, reg_rdata, m_read(a));
    end
  endtask

  task automatic run_rand(input int n, input logic [5:0] idh);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_valid  = ($urandom % 4) != 0;
      ev_client = ($urandom % 2) ? idh : 6'($urandom % 4);
      ev_class  = 9'($urandom);
      ev_prio   = 3'($urandom);
    end
  endtask

  task automatic run_full(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_valid = 1; ev_client = 6'd5; ev_class = 9'h1FF; ev_prio = 3'b111;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int dummy;
    logic [31:0] w0, w1;
    dummy = $urandom(32'h5EED_0042);
    checks = 0; errors = 0; done = 0;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(8'hB8, 32'd0, "R1 cnt0");
    chk(8'hBC, 32'd0, "R1 cnt1");
    chk(8'hA4, 32'd0, "R1 clks");
    chk(8'hA0, 32'h0000FFFF, "R1 limit");
    chk(8'hA8, 32'd0, "R1 ctl0");
    chk(8'h90, 32'd0, "R1 cmd");

    // R2 field masking
    wr(8'hA8, 32'hFFFFFFFF);
    chk(8'hA8, 32'h37FF3F00, "R2 ctl0 mask");
    wr(8'hAC, 32'h0000_00FF);
    chk(8'hAC, 32'h0, "R2 ctl1 mask");

    // R11 unmapped reads and ignored writes
    chk(8'h44, 32'd0, "R11 unmapped");
    chk(8'hFC, 32'd0, "R11 unmapped");
    wr(8'hB8, 32'h55); wr(8'hA4, 32'h77);
    chk(8'hB8, 32'd0, "R11 cnt write ignored");
    chk(8'hA4, 32'd0, "R11 clk write ignored");

    // R9 window closes at the limit
    wr(8'hA8, 32'h0001_0000);      // any read
    wr(8'hAC, 32'h0009_0000);      // code 9: never counts (R3)
    wr(8'hA0, 32'd5);
    wr(8'h90, 32'h100);            // clear
    @(negedge clk); ev_valid = 1; ev_class = 9'h1FF;
    reg_wr = 1; reg_addr = 8'h90; reg_wdata = 32'h300;
    @(negedge clk); reg_wr = 0;
    run_full(19);
    chk(8'hA4, 32'd5, "R9 clks stop at limit");
    chk(8'hB8, 32'd5, "R9 events only inside window");
    chk(8'hBC, 32'd0, "R3 select above 8");
    chk(8'h90, 32'h300, "R6 cmd readback");

    // R10 saturation
    wr(8'hA0, 32'hFFFF);
    wr(8'h90, 32'h100);
    run_full(300);
    chk(8'hB8, 32'h000000FF, "R10 saturate");
    chkm(8'hA4, "R9 clks advance");

    // R6 disable freezes
    wr(8'h90, 32'h200);
    w0 = m_read(8'hA4);
    run_full(20);
    chk(8'hA4, w0, "R6 clks frozen");
    chkm(8'hB8, "R6 cnt frozen");

    // R7 clear while gathering keeps state
    wr(8'hA8, 32'h0002_0000);      // any write
    wr(8'h90, 32'h300);
    run_rand(30, 6'd3);
    wr(8'h90, 32'h100);
    run_rand(10, 6'd3);
    chkm(8'hB8, "R7 counting resumes after clear");
    chk(8'hA8, 32'h0002_0000, "R7 ctl kept");
    chkm(8'hA4, "R7 clks restart");

    // R8 reset command stops gathering
    wr(8'h90, 32'h000);
    run_full(15);
    chk(8'hA4, 32'd0, "R8 clks zero and stopped");
    chk(8'hB8, 32'd0, "R8 cnt zero");

    // R3 R4 R5 R12 random control words against the model
    for (int p = 0; p < 40; p++) begin
      w0 = $urandom & CTL_MASK;
      w1 = $urandom & CTL_MASK;
      w0[23:16] = 8'($urandom % 11);
      w1[23:16] = 8'($urandom % 11);
      if (p % 4 == 0) begin w0[26] = 1; w0[13:8] = 6'($urandom % 4); end
      wr(8'hA8, w0);
      wr(8'hAC, w1);
      wr(8'h90, 32'h100);
      wr(8'h90, 32'h300);
      run_rand(60 + p, w1[13:8]);
      wr(8'h90, 32'h200);
      chkm(8'hB8, "R3 R4 R5 cnt0 random");
      chkm(8'hBC, "R12 cnt1 random");
      chkm(8'hA4, "R9 clks random");
    end

    summary();
  end

endmodule